// File: doc/BRIEF.md
# Message Unit Queue Controller

This block carries 32-bit message handles between a remote host and a local I/O processor core. It uses four circular queues, each held in a small internal RAM. Two inbound queues (IB0, IB1) take handles that the host posts and deliver them to the core. Two outbound queues (OB0, OB1) take handles that the core posts and deliver them to the host. Each side reaches the queues through its own register port. The port is a single-cycle request bus with read data registered one cycle later. The address map is the same on both sides: offset 0 posts to the first queue the side feeds, offset 1 posts to the second, offset 2 fetches from the first queue the side receives, offset 3 fetches from the second, offset 4 holds the sticky overflow status, and offset 5 holds the interrupt mask.

Each queue is governed by a three-state machine. The states are Q_EMPTY, Q_PARTIAL and Q_FULL. A stored post moves Q_EMPTY to Q_PARTIAL. A post without a fetch moves Q_PARTIAL to Q_FULL when the last free entry is used. A fetch without a post moves Q_PARTIAL to Q_EMPTY when the last entry leaves. A fetch moves Q_FULL to Q_PARTIAL. In every other case the state stays where it is. When the depth is one, Q_EMPTY and Q_FULL move directly into each other. A post is accepted unless the queue is in Q_FULL. A fetch takes effect unless the queue is in Q_EMPTY. Both decisions use the state held at the start of the cycle.

Each side has an interrupt output. It stays high while one of the queues that side receives from holds a message and that queue's mask bit is clear.

Top module: `msg_queue_ctrl`

## Requirements
- R1: The host posts to IB0 and IB1 at offsets 0 and 1, and the core fetches them at offsets 2 and 3. The core posts to OB0 and OB1 at offsets 0 and 1, and the host fetches them at offsets 2 and 3.
- R2: Fetches from a queue return its handles in the order they were posted. This holds across wrap-around of the ring pointers.
- R3: Read data appears on the side's rd_data output in the cycle after the read request. It holds its value until the next read request on that side.
- R4: A fetch from an empty queue returns 0xFFFFFFFF and changes no queue.
- R5: A queue holds DEPTH handles (default 8). A post to a full queue is dropped, and the queue contents stay unchanged.
- R6: A dropped post sets a sticky overflow bit in the posting side's status register at offset 4. Bit 0 belongs to the side's first posting queue and bit 1 to its second. Writing 1 to a bit clears it. Writing 0 has no effect. A new overflow wins over a clear in the same cycle.
- R7: A side's irq is high while either of its receiving queues is non-empty and not masked. The mask register is at offset 5, with bit 0 for the first receiving queue and bit 1 for the second. A 1 masks that queue.
- R8: After reset, all queues are empty, both irq outputs are low, and the status, mask and read data registers read 0.
- R9: A write to a fetch offset has no effect. A read of a post offset returns 0 and changes no queue.
- R10: A post from one side and a fetch from the other side on the same queue in the same cycle both take effect. If the queue was full at the start of that cycle, the fetch succeeds and the post is dropped as an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req_vld | input | 1 | Host request valid |
| h_req_wr | input | 1 | Host request is a write |
| h_req_addr | input | 3 | Host register offset |
| h_req_wdata | input | 32 | Host write data |
| h_rd_data | output | 32 | Host read data, one cycle after the request |
| h_irq | output | 1 | Host interrupt: an outbound message is waiting |
| c_req_vld | input | 1 | Core request valid |
| c_req_wr | input | 1 | Core request is a write |
| c_req_addr | input | 3 | Core register offset |
| c_req_wdata | input | 32 | Core write data |
| c_rd_data | output | 32 | Core read data, one cycle after the request |
| c_irq | output | 1 | Core interrupt: an inbound message is waiting |

## Verification
The assertions check four things on every cycle: the all-ones answer to a fetch from an empty queue, that a full queue stays full until it is fetched from, that the overflow bit is set and then sticks until cleared, and that each interrupt follows the queue occupancy and its mask. Only the bench's scenarios can show that handles come out in posting order through pointer wrap-around and that a dropped post leaves the stored handles untouched. They also show what happens when both sides post and fetch the same queue in one cycle, and that read data holds between requests.

// File: rtl/mq_pkg.sv
`timescale 1ns/1ps
package mq_pkg;
    // Register offsets, identical on both sides
    localparam int unsigned OFS_POST0 = 0;
    localparam int unsigned OFS_POST1 = 1;
    localparam int unsigned OFS_FETCH0 = 2;
    localparam int unsigned OFS_FETCH1 = 3;
    localparam int unsigned OFS_STAT = 4;
    localparam int unsigned OFS_MASK = 5;

    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } qstate_e;
endpackage

// File: rtl/mq_ring.sv
`timescale 1ns/1ps
module mq_ring #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         nonempty_o,
    output logic         full_o
);
    import mq_pkg::*;

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    qstate_e        state_q, state_d;
    logic [PW-1:0]  head_q, tail_q;
    logic [CW-1:0]  cnt_q;
    logic [W-1:0]   mem_q [DEPTH];
    logic           do_push, do_pop;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign do_push = push_i && (state_q != Q_FULL);
    assign do_pop  = pop_i && (state_q != Q_EMPTY);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= Q_EMPTY;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_EMPTY: begin
                if (do_push) state_d = (DEPTH == 1) ? Q_FULL : Q_PARTIAL;
            end
            Q_PARTIAL: begin
                if (do_push && !do_pop && cnt_q == CW'(DEPTH - 1))
                    state_d = Q_FULL;
                else if (do_pop && !do_push && cnt_q == CW'(1))
                    state_d = Q_EMPTY;
            end
            Q_FULL: begin
                if (do_pop) state_d = (DEPTH == 1) ? Q_EMPTY : Q_PARTIAL;
            end
            default: state_d = Q_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        nonempty_o = (state_q != Q_EMPTY);
        full_o     = (state_q == Q_FULL);
        head_o     = mem_q[head_q];
    end

    // Pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_push) tail_q <= wrap_inc(tail_q);
            if (do_pop)  head_q <= wrap_inc(head_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + CW'(1);
            else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
        end
    end

    // Storage
    always_ff @(posedge clk) begin
        if (do_push) mem_q[tail_q] <= data_i;
    end
endmodule

// File: rtl/mq_port.sv
`timescale 1ns/1ps
module mq_port #(
    parameter int W  = 32,
    parameter int AW = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_vld,
    input  logic                req_wr,
    input  logic [AW-1:0]       req_addr,
    input  logic [W-1:0]        req_wdata,
    input  logic [1:0]          tx_full,
    input  logic [1:0][W-1:0]   rx_head,
    input  logic [1:0]          rx_nonempty,
    output logic [1:0]          push_o,
    output logic [W-1:0]        push_data_o,
    output logic [1:0]          pop_o,
    output logic [W-1:0]        rd_data_o,
    output logic                irq_o,
    output logic [1:0]          ovf_o,
    output logic [1:0]          mask_o
);
    import mq_pkg::*;

    logic          wr, rd;
    logic [1:0]    ovf_q, mask_q;
    logic [W-1:0]  rd_data_q;

    assign wr = req_vld && req_wr;
    assign rd = req_vld && !req_wr;

    assign push_o[0]   = wr && (req_addr == AW'(OFS_POST0));
    assign push_o[1]   = wr && (req_addr == AW'(OFS_POST1));
    assign pop_o[0]    = rd && (req_addr == AW'(OFS_FETCH0));
    assign pop_o[1]    = rd && (req_addr == AW'(OFS_FETCH1));
    assign push_data_o = req_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q  <= '0;
            mask_q <= '0;
        end else begin
            for (int k = 0; k < 2; k++) begin
                if (push_o[k] && tx_full[k])
                    ovf_q[k] <= 1'b1;
                else if (wr && req_addr == AW'(OFS_STAT) && req_wdata[k])
                    ovf_q[k] <= 1'b0;
            end
            if (wr && req_addr == AW'(OFS_MASK)) mask_q <= req_wdata[1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q <= '0;
        end else if (rd) begin
            if (req_addr == AW'(OFS_FETCH0))
                rd_data_q <= rx_nonempty[0] ? rx_head[0] : '1;
            else if (req_addr == AW'(OFS_FETCH1))
                rd_data_q <= rx_nonempty[1] ? rx_head[1] : '1;
            else if (req_addr == AW'(OFS_STAT))
                rd_data_q <= W'(ovf_q);
            else if (req_addr == AW'(OFS_MASK))
                rd_data_q <= W'(mask_q);
            else
                rd_data_q <= '0;
        end
    end

    assign rd_data_o = rd_data_q;
    assign irq_o     = |(rx_nonempty & ~mask_q);
    assign ovf_o     = ovf_q;
    assign mask_o    = mask_q;
endmodule

// File: rtl/msg_queue_ctrl.sv
`timescale 1ns/1ps
module msg_queue_ctrl #(
    parameter int W     = 32,
    parameter int AW    = 3,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_req_vld,
    input  logic          h_req_wr,
    input  logic [AW-1:0] h_req_addr,
    input  logic [W-1:0]  h_req_wdata,
    output logic [W-1:0]  h_rd_data,
    output logic          h_irq,
    input  logic          c_req_vld,
    input  logic          c_req_wr,
    input  logic [AW-1:0] c_req_addr,
    input  logic [W-1:0]  c_req_wdata,
    output logic [W-1:0]  c_rd_data,
    output logic          c_irq
);
    localparam int NQ = 4;  // 0:IB0 1:IB1 2:OB0 3:OB1

    logic [NQ-1:0]         q_push, q_pop, q_nonempty, q_full;
    logic [NQ-1:0][W-1:0]  q_head, q_wdata;
    logic [1:0]            h_push, h_pop, c_push, c_pop;
    logic [W-1:0]          h_push_data, c_push_data;
    logic [1:0]            h_ovf, c_ovf, h_mask, c_mask;

    assign q_push = {c_push, h_push};
    assign q_pop  = {h_pop, c_pop};

    for (genvar k = 0; k < NQ; k++) begin : g_q
        if (k < 2) begin : g_in
            assign q_wdata[k] = h_push_data;
        end else begin : g_out
            assign q_wdata[k] = c_push_data;
        end
        mq_ring #(.W(W), .DEPTH(DEPTH)) u_ring (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_i     (q_push[k]),
            .data_i     (q_wdata[k]),
            .pop_i      (q_pop[k]),
            .head_o     (q_head[k]),
            .nonempty_o (q_nonempty[k]),
            .full_o     (q_full[k])
        );
    end

    mq_port #(.W(W), .AW(AW)) u_host (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_vld     (h_req_vld),
        .req_wr      (h_req_wr),
        .req_addr    (h_req_addr),
        .req_wdata   (h_req_wdata),
        .tx_full     (q_full[1:0]),
        .rx_head     (q_head[3:2]),
        .rx_nonempty (q_nonempty[3:2]),
        .push_o      (h_push),
        .push_data_o (h_push_data),
        .pop_o       (h_pop),
        .rd_data_o   (h_rd_data),
        .irq_o       (h_irq),
        .ovf_o       (h_ovf),
        .mask_o      (h_mask)
    );

    mq_port #(.W(W), .AW(AW)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_vld     (c_req_vld),
        .req_wr      (c_req_wr),
        .req_addr    (c_req_addr),
        .req_wdata   (c_req_wdata),
        .tx_full     (q_full[3:2]),
        .rx_head     (q_head[1:0]),
        .rx_nonempty (q_nonempty[1:0]),
        .push_o      (c_push),
        .push_data_o (c_push_data),
        .pop_o       (c_pop),
        .rd_data_o   (c_rd_data),
        .irq_o       (c_irq),
        .ovf_o       (c_ovf),
        .mask_o      (c_mask)
    );
endmodule

// File: rtl/mq_checker.sv
`timescale 1ns/1ps
module mq_checker #(
    parameter int W  = 32,
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          h_req_vld,
    input logic          h_req_wr,
    input logic [AW-1:0] h_req_addr,
    input logic          h_clr0,
    input logic [W-1:0]  h_rd_data,
    input logic          h_irq,
    input logic          c_req_vld,
    input logic          c_req_wr,
    input logic [AW-1:0] c_req_addr,
    input logic [W-1:0]  c_rd_data,
    input logic          c_irq,
    input logic          ne_ib0,
    input logic          ne_ob0,
    input logic          ne_ob1,
    input logic          full_ib0,
    input logic          full_ob0,
    input logic          h_ovf0,
    input logic          c_ovf0,
    input logic          c_mask0
);
    logic h_fetch0, c_fetch0, c_post0, h_clr_req;

    assign h_fetch0  = h_req_vld && !h_req_wr && h_req_addr == AW'(2);
    assign c_fetch0  = c_req_vld && !c_req_wr && c_req_addr == AW'(2);
    assign c_post0   = c_req_vld && c_req_wr && c_req_addr == AW'(0);
    assign h_clr_req = h_req_vld && h_req_wr && h_req_addr == AW'(4) && h_clr0;

    // R4: empty fetch answers all ones
    a_r4_host_empty_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (h_fetch0 && !ne_ob0) |=> (h_rd_data == '1));
    a_r4_core_empty_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (c_fetch0 && !ne_ib0) |=> (c_rd_data == '1));

    // R5: a full queue stays full until it is fetched from
    a_r5_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full_ib0 && !c_fetch0) |=> full_ib0);

    // R6: overflow sets and then sticks until cleared
    a_r6_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (c_post0 && full_ob0) |=> c_ovf0);
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (h_ovf0 && !h_clr_req) |=> h_ovf0);

    // R7: interrupt follows occupancy and mask
    a_r7_core_irq_on: assert property (@(posedge clk) disable iff (!rst_n)
        (ne_ib0 && !c_mask0) |-> c_irq);
    a_r7_host_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!ne_ob0 && !ne_ob1) |-> !h_irq);
endmodule

bind msg_queue_ctrl mq_checker #(.W(W), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .h_req_vld  (h_req_vld),
    .h_req_wr   (h_req_wr),
    .h_req_addr (h_req_addr),
    .h_clr0     (h_req_wdata[0]),
    .h_rd_data  (h_rd_data),
    .h_irq      (h_irq),
    .c_req_vld  (c_req_vld),
    .c_req_wr   (c_req_wr),
    .c_req_addr (c_req_addr),
    .c_rd_data  (c_rd_data),
    .c_irq      (c_irq),
    .ne_ib0     (q_nonempty[0]),
    .ne_ob0     (q_nonempty[2]),
    .ne_ob1     (q_nonempty[3]),
    .full_ib0   (q_full[0]),
    .full_ob0   (q_full[2]),
    .h_ovf0     (h_ovf[0]),
    .c_ovf0     (c_ovf[0]),
    .c_mask0    (c_mask[0])
);

// File: tb/tb_msg_queue_ctrl.sv
`timescale 1ns/1ps
module tb_msg_queue_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_req_vld = 1'b0, h_req_wr = 1'b0;
    logic [2:0]  h_req_addr = '0;
    logic [31:0] h_req_wdata = '0;
    logic [31:0] h_rd_data;
    logic        h_irq;
    logic        c_req_vld = 1'b0, c_req_wr = 1'b0;
    logic [2:0]  c_req_addr = '0;
    logic [31:0] c_req_wdata = '0;
    logic [31:0] c_rd_data;
    logic        c_irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    msg_queue_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .h_req_vld(h_req_vld), .h_req_wr(h_req_wr), .h_req_addr(h_req_addr),
        .h_req_wdata(h_req_wdata), .h_rd_data(h_rd_data), .h_irq(h_irq),
        .c_req_vld(c_req_vld), .c_req_wr(c_req_wr), .c_req_addr(c_req_addr),
        .c_req_wdata(c_req_wdata), .c_rd_data(c_rd_data), .c_irq(c_irq)
    );

    // {side(1: core), wr, addr[2:0], wdata[31:0], chk, exp[31:0]}
    localparam int NV = 14;
    localparam logic [69:0] VEC [NV] = '{
        {1'b0, 1'b1, 3'd0, 32'h000000A1, 1'b0, 32'h0},         // R1 host post IB0
        {1'b0, 1'b1, 3'd0, 32'h000000A2, 1'b0, 32'h0},         // R1 host post IB0
        {1'b0, 1'b1, 3'd1, 32'h000000B1, 1'b0, 32'h0},         // R1 host post IB1
        {1'b1, 1'b0, 3'd2, 32'h0, 1'b1, 32'h000000A1},         // R1 R2 core fetch IB0
        {1'b1, 1'b0, 3'd3, 32'h0, 1'b1, 32'h000000B1},         // R1 core fetch IB1
        {1'b1, 1'b0, 3'd2, 32'h0, 1'b1, 32'h000000A2},         // R2 order
        {1'b1, 1'b0, 3'd2, 32'h0, 1'b1, 32'hFFFFFFFF},         // R4 empty
        {1'b1, 1'b1, 3'd0, 32'h000000C1, 1'b0, 32'h0},         // R1 core post OB0
        {1'b0, 1'b0, 3'd2, 32'h0, 1'b1, 32'h000000C1},         // R1 host fetch OB0
        {1'b0, 1'b0, 3'd3, 32'h0, 1'b1, 32'hFFFFFFFF},         // R4 OB1 empty
        {1'b0, 1'b0, 3'd0, 32'h0, 1'b1, 32'h0},                // R9 read of post offset
        {1'b1, 1'b1, 3'd2, 32'h0000DEAD, 1'b0, 32'h0},         // R9 write to fetch offset
        {1'b1, 1'b0, 3'd2, 32'h0, 1'b1, 32'hFFFFFFFF},         // R9 IB0 still empty
        {1'b0, 1'b0, 3'd5, 32'h0, 1'b1, 32'h0}                 // R8 host mask at reset
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // One request on one side; returns at the next falling edge with read data valid
    task automatic op(input bit core, input bit wr, input logic [2:0] addr, input logic [31:0] wd);
        if (core) begin
            c_req_vld = 1'b1; c_req_wr = wr; c_req_addr = addr; c_req_wdata = wd;
        end else begin
            h_req_vld = 1'b1; h_req_wr = wr; h_req_addr = addr; h_req_wdata = wd;
        end
        @(negedge clk);
        h_req_vld = 1'b0;
        c_req_vld = 1'b0;
    endtask

    // Host and core requests in the same cycle
    task automatic op2(input bit hwr, input logic [2:0] ha, input logic [31:0] hd,
                       input bit cwr, input logic [2:0] ca, input logic [31:0] cd);
        h_req_vld = 1'b1; h_req_wr = hwr; h_req_addr = ha; h_req_wdata = hd;
        c_req_vld = 1'b1; c_req_wr = cwr; c_req_addr = ca; c_req_wdata = cd;
        @(negedge clk);
        h_req_vld = 1'b0;
        c_req_vld = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        check("R8 h_irq", {31'b0, h_irq}, 32'h0);
        check("R8 c_irq", {31'b0, c_irq}, 32'h0);
        check("R8 rd_data", c_rd_data, 32'h0);
        op(1'b0, 1'b0, 3'd4, '0);
        check("R8 host status", h_rd_data, 32'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            op(VEC[i][69], VEC[i][68], VEC[i][67:65], VEC[i][64:33]);
            if (VEC[i][32])
                check($sformatf("R1/R2/R4/R9 vector %0d", i),
                      VEC[i][69] ? c_rd_data : h_rd_data, VEC[i][31:0]);
        end

        // R5 R6 R2: fill IB0 across pointer wrap, then one post too many
        for (int i = 0; i < 9; i++) op(1'b0, 1'b1, 3'd0, 32'h100 + i);
        check("R7 core irq with IB0 pending", {31'b0, c_irq}, 32'h1);
        op(1'b0, 1'b0, 3'd4, '0);
        check("R6 overflow set", h_rd_data, 32'h1);
        for (int i = 0; i < 8; i++) begin
            op(1'b1, 1'b0, 3'd2, '0);
            check("R2 wrap order", c_rd_data, 32'h100 + i);
        end
        op(1'b1, 1'b0, 3'd2, '0);
        check("R5 dropped post not stored", c_rd_data, 32'hFFFFFFFF);
        op(1'b0, 1'b1, 3'd4, 32'h0);
        op(1'b0, 1'b1, 3'd4, 32'h2);
        op(1'b0, 1'b0, 3'd4, '0);
        check("R6 write 0 keeps bit", h_rd_data, 32'h1);
        op(1'b0, 1'b1, 3'd4, 32'h1);
        op(1'b0, 1'b0, 3'd4, '0);
        check("R6 write 1 clears", h_rd_data, 32'h0);

        // R7 mask and R3 hold
        op(1'b1, 1'b1, 3'd5, 32'h1);
        op(1'b0, 1'b1, 3'd0, 32'h55);
        check("R7 masked core irq", {31'b0, c_irq}, 32'h0);
        op(1'b1, 1'b0, 3'd5, '0);
        check("R7 mask readback", c_rd_data, 32'h1);
        op(1'b1, 1'b1, 3'd5, 32'h0);
        check("R7 unmasked core irq", {31'b0, c_irq}, 32'h1);
        op(1'b1, 1'b0, 3'd2, '0);
        check("R2 fetch after mask", c_rd_data, 32'h55);
        check("R7 core irq clears", {31'b0, c_irq}, 32'h0);
        repeat (3) @(negedge clk);
        check("R3 read data holds", c_rd_data, 32'h55);
        op(1'b1, 1'b1, 3'd1, 32'h77);
        check("R7 host irq on OB1", {31'b0, h_irq}, 32'h1);
        op(1'b0, 1'b0, 3'd3, '0);
        check("R1 host fetch OB1", h_rd_data, 32'h77);
        check("R7 host irq clears", {31'b0, h_irq}, 32'h0);

        // R10 simultaneous post and fetch
        op(1'b0, 1'b1, 3'd0, 32'hA0);
        op2(1'b1, 3'd0, 32'hA1, 1'b0, 3'd2, '0);
        check("R10 fetch during post", c_rd_data, 32'hA0);
        op(1'b1, 1'b0, 3'd2, '0);
        check("R10 post during fetch kept", c_rd_data, 32'hA1);

        // R10 on a full queue: fetch wins, post dropped
        for (int i = 0; i < 8; i++) op(1'b0, 1'b1, 3'd0, 32'h200 + i);
        op2(1'b1, 3'd0, 32'hBAD, 1'b0, 3'd2, '0);
        check("R10 fetch from full", c_rd_data, 32'h200);
        op(1'b0, 1'b0, 3'd4, '0);
        check("R10 post to full overflows", h_rd_data, 32'h1);
        for (int i = 1; i < 8; i++) begin
            op(1'b1, 1'b0, 3'd2, '0);
            check("R10 drain", c_rd_data, 32'h200 + i);
        end
        op(1'b1, 1'b0, 3'd2, '0);
        check("R10 dropped handle absent", c_rd_data, 32'hFFFFFFFF);

        summary();
    end
endmodule